// File: doc/BRIEF.md
# Dual-Channel Interrupt Pending and Vector Unit

This unit keeps the receive and transmit interrupt state of two serial channels, called A and B. For each channel it holds a pending flag and an in-service flag for receive and for transmit. From these it drives one shared interrupt request line, a pending-bits byte and a modified vector byte. Single-cycle event pulses change the state: a character received, the transmit buffer going empty, a data read, a command that resets the transmit pending flag, and a command that resets the highest in-service flag. Configuration inputs choose whether transmit and receive interrupts are enabled, the receive interrupt mode, break interrupt enabling, and whether the vector code sits in the low or the high bit positions.

While a receive is in service, transmit events cannot change the vector or the pending byte. Clearing a receive re-raises any transmit that is still pending. Clearing a transmit re-raises any receive that is still pending. The pending byte and the vector byte are read directly by the register-read logic around the unit.

Top module: `ivl_top`

## Requirements
- R1: During reset and on the first cycle after it, `irq` is 0, `pend_reg` is 0x00 and `vec_reg` is 0x00.
- R2: A receive event on a channel sets that channel's receive pending bit in `pend_reg` (bit 5 for A, bit 2 for B) and loads that channel's receive vector code into `vec_reg`. Both take effect on the next cycle.
- R3: With `vec_hi`=0 the vector codes are: A receive 0x0C, A transmit 0x08, B receive 0x04, B transmit 0x00, none 0x06. With `vec_hi`=1 they are: A receive 0x30, A transmit 0x10, B receive 0x20, B transmit 0x00, none 0x60.
- R4: A transmit event on a channel with no receive in service loads that channel's transmit vector code. It sets the transmit pending bit (bit 4 for A, bit 1 for B) only when that channel's `tx_ie` is 1.
- R5: A transmit event on a channel whose receive is in service leaves `vec_reg` and that channel's pending bits unchanged.
- R6: A reset-highest-in-service command on a channel with a receive in service ends that service and re-raises a pending transmit, which loads the transmit code and sets its pending bit. With no receive in service, the command ends only the transmit service and leaves `vec_reg` and `pend_reg` unchanged.
- R7: A data read on a channel clears its receive pending flag and pending bit and loads the no-interrupt code. If a transmit is still pending on that channel, the transmit is then re-raised.
- R8: A reset-transmit-pending command on a channel clears its transmit pending flag and pending bit and loads the no-interrupt code. If a receive is still pending on that channel, the receive is then re-raised.
- R9: `irq` is 1 when either channel has any of these: a transmit pending with `tx_ie`=1; a receive pending with its receive mode equal to 2'b01 or 2'b10; or break enable and break status both at 1.
- R10: The external pending bit of a channel (bit 3 for A, bit 0 for B) equals the AND of that channel's break enable and break status one cycle earlier.
- R11: When both channels have events in the same cycle, channel A is handled first, so `vec_reg` ends with the code from channel B. Within one channel, the order is: read, receive, reset-transmit-pending, transmit, reset-highest-in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_evt | input | 2 | Character received pulse (bit 1 = A, bit 0 = B) |
| tx_evt | input | 2 | Transmit buffer empty pulse |
| rd_evt | input | 2 | Receive data read pulse |
| clr_tx_cmd | input | 2 | Reset transmit pending command pulse |
| clr_ius_cmd | input | 2 | Reset highest in-service command pulse |
| vec_hi | input | 1 | Place vector code in high bit positions |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode_a | input | 2 | Channel A receive interrupt mode |
| rx_mode_b | input | 2 | Channel B receive interrupt mode |
| brk_en | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| irq | output | 1 | Shared interrupt request |
| pend_reg | output | 8 | Pending-bits byte |
| vec_reg | output | 8 | Modified vector byte |

## Verification
The assertions assume that event inputs are sampled only on rising edges, and that configuration inputs are held steady while the events they qualify are being handled. The receive-pending checks expect no data read for the same channel in the same cycle. The transmit-blocking check applies only when a transmit event arrives alone. The stimulus changes inputs only on falling edges, pulses each event for exactly one cycle, and changes configuration only between scenarios while no event is active. Simultaneous events appear only in the ordering scenario, and there each event type is applied to both channels at once.

// File: rtl/ivl_pkg.sv
// Shared types and state-update functions for the interrupt vector unit.
// Assumes channel index 1 is channel A and index 0 is channel B.
package ivl_pkg;

    localparam int NCH     = 2;
    localparam int BYTE_W  = 8;
    localparam int BITS_CH = 3;   // ext, tx, rx bits per channel in pend byte

    typedef struct packed {
        logic [NCH-1:0]    rxp;   // receive pending
        logic [NCH-1:0]    txp;   // transmit pending
        logic [NCH-1:0]    rxs;   // receive in service
        logic [NCH-1:0]    txs;   // transmit in service
        logic [BYTE_W-1:0] pend;
        logic [BYTE_W-1:0] vec;
    } ivl_state_t;

    // Vector code for a channel source, low or high placement
    function automatic logic [BYTE_W-1:0] vec_code(input int c, input logic is_rx,
                                                  input logic hi);
        logic [BYTE_W-1:0] v;
        if (hi) begin
            if (c == 1) v = is_rx ? 8'h30 : 8'h10;
            else        v = is_rx ? 8'h20 : 8'h00;
        end else begin
            if (c == 1) v = is_rx ? 8'h0C : 8'h08;
            else        v = is_rx ? 8'h04 : 8'h00;
        end
        return v;
    endfunction

    // No-interrupt code
    function automatic logic [BYTE_W-1:0] vec_none(input logic hi);
        return hi ? 8'h60 : 8'h06;
    endfunction

    // Raise receive: pending, in service, pend bit, vector
    function automatic ivl_state_t f_set_rx(input ivl_state_t s, input int c,
                                            input logic hi);
        ivl_state_t r = s;
        r.rxp[c] = 1'b1;
        r.rxs[c] = 1'b1;
        r.pend[BITS_CH*c+2] = 1'b1;
        r.vec = vec_code(c, 1'b1, hi);
        return r;
    endfunction

    // Raise transmit: blocked from vector/pend while receive is in service
    function automatic ivl_state_t f_set_tx(input ivl_state_t s, input int c,
                                            input logic hi, input logic ie);
        ivl_state_t r = s;
        r.txp[c] = 1'b1;
        if (!r.rxs[c]) begin
            r.txs[c] = 1'b1;
            if (ie) r.pend[BITS_CH*c+1] = 1'b1;
            r.vec = vec_code(c, 1'b0, hi);
        end
        return r;
    endfunction

    // Clear receive, then re-raise a pending transmit
    function automatic ivl_state_t f_clr_rx(input ivl_state_t s, input int c,
                                            input logic hi, input logic ie);
        ivl_state_t r = s;
        r.rxp[c] = 1'b0;
        r.rxs[c] = 1'b0;
        r.vec = vec_none(hi);
        r.pend[BITS_CH*c+2] = 1'b0;
        if (r.txp[c]) r = f_set_tx(r, c, hi, ie);
        return r;
    endfunction

    // Clear transmit, then re-raise a pending receive
    function automatic ivl_state_t f_clr_tx(input ivl_state_t s, input int c,
                                            input logic hi);
        ivl_state_t r = s;
        r.txp[c] = 1'b0;
        r.txs[c] = 1'b0;
        r.vec = vec_none(hi);
        r.pend[BITS_CH*c+1] = 1'b0;
        if (r.rxp[c]) r = f_set_rx(r, c, hi);
        return r;
    endfunction

    // End the highest service: receive first, else transmit
    function automatic ivl_state_t f_end_ius(input ivl_state_t s, input int c,
                                             input logic hi, input logic ie);
        ivl_state_t r = s;
        if (r.rxs[c]) begin
            r.rxs[c] = 1'b0;
            if (r.txp[c]) r = f_set_tx(r, c, hi, ie);
        end else begin
            r.txs[c] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ivl_chan_req.sv
// Per-channel interrupt request decode.
// Combinational; assumes pending flags come from registered state.
module ivl_chan_req (
    input  logic       tx_pend,
    input  logic       rx_pend,
    input  logic       tx_ie,
    input  logic [1:0] rx_mode,
    input  logic       brk_en,
    input  logic       brk_stat,
    output logic       req
);
    logic rx_mode_ok;

    // Receive interrupts on first-char or all-char modes only
    always_comb rx_mode_ok = (rx_mode == 2'b01) || (rx_mode == 2'b10);

    // Combine transmit, receive and break causes
    always_comb req = (tx_ie & tx_pend) | (rx_mode_ok & rx_pend) | (brk_en & brk_stat);

endmodule

// File: rtl/ivl_top.sv
// Dual-channel receive/transmit interrupt pending and vector unit.
// Assumes event inputs are one-cycle pulses sampled on the rising edge;
// all state updates appear on the following cycle, channel A before B.
module ivl_top
    import ivl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   rx_evt,
    input  logic [NCH-1:0]   tx_evt,
    input  logic [NCH-1:0]   rd_evt,
    input  logic [NCH-1:0]   clr_tx_cmd,
    input  logic [NCH-1:0]   clr_ius_cmd,
    input  logic             vec_hi,
    input  logic [NCH-1:0]   tx_ie,
    input  logic [1:0]       rx_mode_a,
    input  logic [1:0]       rx_mode_b,
    input  logic [NCH-1:0]   brk_en,
    input  logic [NCH-1:0]   brk_stat,
    output logic             irq,
    output logic [BYTE_W-1:0] pend_reg,
    output logic [BYTE_W-1:0] vec_reg
);
    ivl_state_t       st, st_nxt;
    logic [NCH-1:0]   chan_req;

    // Apply events in fixed order: channel A first, then B
    always_comb begin
        st_nxt = st;
        for (int i = 0; i < NCH; i++) begin
            int c;
            c = NCH - 1 - i;
            if (rd_evt[c])      st_nxt = f_clr_rx(st_nxt, c, vec_hi, tx_ie[c]);
            if (rx_evt[c])      st_nxt = f_set_rx(st_nxt, c, vec_hi);
            if (clr_tx_cmd[c])  st_nxt = f_clr_tx(st_nxt, c, vec_hi);
            if (tx_evt[c])      st_nxt = f_set_tx(st_nxt, c, vec_hi, tx_ie[c]);
            if (clr_ius_cmd[c]) st_nxt = f_end_ius(st_nxt, c, vec_hi, tx_ie[c]);
        end
        for (int c = 0; c < NCH; c++) begin
            st_nxt.pend[BITS_CH*c] = brk_en[c] & brk_stat[c];
        end
        st_nxt.pend[BYTE_W-1:BITS_CH*NCH] = '0;
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= st_nxt;
    end

    // Per-channel request decoders
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_req
            ivl_chan_req u_req (
                .tx_pend (st.txp[g]),
                .rx_pend (st.rxp[g]),
                .tx_ie   (tx_ie[g]),
                .rx_mode ((g == 1) ? rx_mode_a : rx_mode_b),
                .brk_en  (brk_en[g]),
                .brk_stat(brk_stat[g]),
                .req     (chan_req[g])
            );
        end
    endgenerate

    // Shared request line and register views
    always_comb begin
        irq      = |chan_req;
        pend_reg = st.pend;
        vec_reg  = st.vec;
    end

    // R1: reset clears outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pend_reg == 8'h00 && vec_reg == 8'h00));

    // R2: receive event sets channel A / B receive pending bit
    a_r2_rx_pend_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt[1] && !rd_evt[1]) |=> pend_reg[5]);
    a_r2_rx_pend_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt[0] && !rd_evt[0]) |=> pend_reg[2]);

    // R3: vector always holds a legal code
    a_r3_legal_vec: assert property (@(posedge clk) disable iff (!rst_n)
        vec_reg inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

    // R5: lone transmit event during receive service changes nothing visible
    a_r5_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (st.rxs[1] && tx_evt == 2'b10 && rx_evt == 2'b00 && rd_evt == 2'b00 &&
         clr_tx_cmd == 2'b00 && clr_ius_cmd == 2'b00)
        |=> ($stable(vec_reg) && $stable(pend_reg[5:4])));

    // R9: no enabled cause means no request
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie == 2'b00 && rx_mode_a[0] == rx_mode_a[1] && rx_mode_b[0] == rx_mode_b[1] &&
         brk_en == 2'b00) |-> !irq);

    // R10: break status reaches external pending bit next cycle
    a_r10_brk_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_en[1] && brk_stat[1]) |=> pend_reg[3]);

endmodule

// File: tb/tb_ivl_top.sv
module tb_ivl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_evt = '0, tx_evt = '0, rd_evt = '0, clr_tx_cmd = '0, clr_ius_cmd = '0;
    logic       vec_hi = 1'b0;
    logic [1:0] tx_ie = 2'b11;
    logic [1:0] rx_mode_a = 2'b01, rx_mode_b = 2'b01;
    logic [1:0] brk_en = '0, brk_stat = '0;
    logic       irq;
    logic [7:0] pend_reg, vec_reg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ivl_top dut (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .rd_evt(rd_evt),
        .clr_tx_cmd(clr_tx_cmd), .clr_ius_cmd(clr_ius_cmd), .vec_hi(vec_hi), .tx_ie(tx_ie),
        .rx_mode_a(rx_mode_a), .rx_mode_b(rx_mode_b), .brk_en(brk_en), .brk_stat(brk_stat),
        .irq(irq), .pend_reg(pend_reg), .vec_reg(vec_reg)
    );

    task automatic chk(input string req, input logic [7:0] p, input logic [7:0] v, input logic q);
        n_chk++;
        if (pend_reg !== p || vec_reg !== v || irq !== q) begin
            n_fail++;
            $display("FAIL %s: pend=%02h vec=%02h irq=%0b expected pend=%02h vec=%02h irq=%0b",
                     req, pend_reg, vec_reg, irq, p, v, q);
        end
    endtask

    // One-cycle event pulse; returns at the next falling edge
    task automatic pulse(input logic [1:0] rx, input logic [1:0] tx, input logic [1:0] rd,
                         input logic [1:0] ct, input logic [1:0] ci);
        rx_evt = rx; tx_evt = tx; rd_evt = rd; clr_tx_cmd = ct; clr_ius_cmd = ci;
        @(negedge clk);
        rx_evt = '0; tx_evt = '0; rd_evt = '0; clr_tx_cmd = '0; clr_ius_cmd = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 in reset", 8'h00, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_rx_basic;
        pulse(2'b10, 0, 0, 0, 0);
        chk("R2 rx A", 8'h20, 8'h0C, 1'b1);
        pulse(0, 0, 2'b10, 0, 0);
        chk("R7 read A", 8'h00, 8'h06, 1'b0);
    endtask

    task automatic t_tx_basic;
        pulse(0, 2'b01, 0, 0, 0);
        chk("R4 tx B", 8'h02, 8'h00, 1'b1);
        pulse(0, 0, 0, 2'b01, 0);
        chk("R8 clr tx B", 8'h00, 8'h06, 1'b0);
        tx_ie = 2'b00;
        pulse(0, 2'b10, 0, 0, 0);
        chk("R4 tx A ie off", 8'h00, 8'h08, 1'b0);
        pulse(0, 0, 0, 2'b10, 0);
        chk("R8 clr tx A ie off", 8'h00, 8'h06, 1'b0);
        tx_ie = 2'b11;
    endtask

    task automatic t_rx_blocks_tx;
        pulse(2'b10, 0, 0, 0, 0);
        chk("R2 rx A", 8'h20, 8'h0C, 1'b1);
        pulse(0, 2'b10, 0, 0, 0);
        chk("R5 tx A blocked", 8'h20, 8'h0C, 1'b1);
        pulse(0, 0, 0, 0, 2'b10);
        chk("R6 ius ends rx, tx re-raised", 8'h30, 8'h08, 1'b1);
        pulse(0, 0, 0, 0, 2'b10);
        chk("R6 ius ends tx only", 8'h30, 8'h08, 1'b1);
        pulse(0, 0, 2'b10, 0, 0);
        chk("R7 read re-raises tx", 8'h10, 8'h08, 1'b1);
        pulse(0, 0, 0, 2'b10, 0);
        chk("R8 clr tx A idle", 8'h00, 8'h06, 1'b0);
    endtask

    task automatic t_clr_tx_raises_rx;
        pulse(2'b01, 0, 0, 0, 0);
        chk("R2 rx B", 8'h04, 8'h04, 1'b1);
        pulse(0, 2'b01, 0, 0, 0);
        chk("R5 tx B blocked", 8'h04, 8'h04, 1'b1);
        pulse(0, 0, 0, 2'b01, 0);
        chk("R8 clr tx re-raises rx", 8'h04, 8'h04, 1'b1);
        pulse(0, 0, 2'b01, 0, 0);
        chk("R7 read B", 8'h00, 8'h06, 1'b0);
    endtask

    task automatic t_high_codes;
        vec_hi = 1'b1;
        pulse(2'b10, 0, 0, 0, 0);
        chk("R3 hi rx A", 8'h20, 8'h30, 1'b1);
        pulse(0, 0, 2'b10, 0, 0);
        chk("R3 hi none", 8'h00, 8'h60, 1'b0);
        pulse(0, 2'b10, 0, 0, 0);
        chk("R3 hi tx A", 8'h10, 8'h10, 1'b1);
        pulse(0, 0, 0, 2'b10, 0);
        chk("R3 hi none A", 8'h00, 8'h60, 1'b0);
        pulse(2'b01, 0, 0, 0, 0);
        chk("R3 hi rx B", 8'h04, 8'h20, 1'b1);
        pulse(0, 0, 2'b01, 0, 0);
        chk("R3 hi none B", 8'h00, 8'h60, 1'b0);
        pulse(0, 2'b01, 0, 0, 0);
        chk("R3 hi tx B", 8'h02, 8'h00, 1'b1);
        pulse(0, 0, 0, 2'b01, 0);
        chk("R3 hi none B2", 8'h00, 8'h60, 1'b0);
        vec_hi = 1'b0;
    endtask

    task automatic t_rx_modes;
        rx_mode_a = 2'b00;
        pulse(2'b10, 0, 0, 0, 0);
        chk("R9 mode 00 no irq", 8'h20, 8'h0C, 1'b0);
        rx_mode_a = 2'b11;
        #1 chk("R9 mode 11 no irq", 8'h20, 8'h0C, 1'b0);
        rx_mode_a = 2'b10;
        #1 chk("R9 mode 10 irq", 8'h20, 8'h0C, 1'b1);
        @(negedge clk);
        pulse(0, 0, 2'b10, 0, 0);
        rx_mode_a = 2'b01;
        chk("R7 read A after modes", 8'h00, 8'h06, 1'b0);
    endtask

    task automatic t_break;
        brk_en = 2'b01; brk_stat = 2'b01;
        #1 chk("R9 break irq immediate", 8'h00, 8'h06, 1'b1);
        @(negedge clk);
        chk("R10 break ext bit B", 8'h01, 8'h06, 1'b1);
        brk_stat = 2'b00;
        @(negedge clk);
        chk("R10 break cleared", 8'h00, 8'h06, 1'b0);
        brk_en = 2'b10; brk_stat = 2'b10;
        @(negedge clk);
        chk("R10 break ext bit A", 8'h08, 8'h06, 1'b1);
        brk_en = 2'b00;
        @(negedge clk);
        chk("R10 break disabled", 8'h00, 8'h06, 1'b0);
        brk_stat = 2'b00;
    endtask

    task automatic t_both;
        pulse(2'b11, 0, 0, 0, 0);
        chk("R11 rx both, B last", 8'h24, 8'h04, 1'b1);
        pulse(0, 0, 2'b11, 0, 0);
        chk("R11 read both", 8'h00, 8'h06, 1'b0);
        pulse(0, 2'b11, 0, 0, 0);
        chk("R11 tx both, B last", 8'h12, 8'h00, 1'b1);
        pulse(0, 0, 0, 2'b11, 0);
        chk("R11 clr tx both", 8'h00, 8'h06, 1'b0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_tx_basic();
        t_rx_blocks_tx();
        t_clr_tx_raises_rx();
        t_high_codes();
        t_rx_modes();
        t_break();
        t_both();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule